// File: doc/BRIEF.md
# Multi-Sector Erase Collector

This block sits between the bus write port of a flash array controller and its erase engine. It watches the bus writes for the six-cycle sector-erase command. When the final cycle arrives, it marks the addressed sector in a bitmap and opens a time-out window. While the window is open, each further write of the sector-erase code adds one more sector. Sectors may be added in any order, and any number of them may be added, from one sector up to every sector of the array.

The window length is counted in microsecond ticks. Each accepted addition restarts the count. When the count runs out with no new addition, the block raises a one-cycle start pulse for the erase engine. It then holds the final bitmap and stays busy until the engine reports that it has finished.

A write other than a sector-erase code during the window abandons the collected set. While the block is busy, every bus write is ignored.

Top module: `sec_erase_collector`

## Requirements
- R1: After a synchronous reset, `sector_map` is all zero and `window_open`, `busy` and `erase_start` are low.
- R2: The command is accepted only as six consecutive writes:
  - first write: data AAh, low address bits 555h;
  - second write: data 55h, low address bits 2AAh;
  - third write: data 80h, low address bits 555h;
  - fourth write: data AAh, low address bits 555h;
  - fifth write: data 55h, low address bits 2AAh;
  - sixth write: data 30h, at any address.

  The low address bits are the bits below the sector field, 12 of them by default. After the clock edge that samples the sixth write, `window_open` is high and the bit of `sector_map` given by the sector field is set. The sector field is `wr_addr[15:12]` by default.
- R3: A write that breaks the sequence before the sixth cycle returns the block to idle. A sector-erase write that then arrives alone opens no window and sets no bit.
- R4: While the window is open, each write with data 30h sets the bit of the addressed sector. Bits accumulate in any order, and all sectors can be set.
- R5: The window closes when 50 ticks (`TIMEOUT_US`) have been sampled since the last accepted sector. At the clock edge that samples the 50th tick, `erase_start` rises, `busy` rises and `window_open` falls. After 49 ticks the window is still open.
- R6: Every sector accepted inside the window restarts the tick count from zero.
- R7: During the window, a write whose data is not 30h clears `sector_map` and returns the block to idle.
- R8: While `busy` is high, all writes are ignored and `sector_map` holds its value. An `erase_done` pulse clears `busy` and `sector_map` at the next clock edge.
- R9: Reset asserted during the window or during busy clears the bitmap and all flags.
- R10: `erase_start` is high for exactly one cycle per launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW (16) | Write address; the upper bits select the sector |
| wr_data | input | 8 | Write data (command code) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| erase_done | input | 1 | Pulse from the erase engine when it finishes |
| sector_map | output | NSEC (16) | Collected sector bitmap |
| erase_start | output | 1 | One-cycle pulse that launches the erase |
| window_open | output | 1 | The time-out window is open |
| busy | output | 1 | The erase is launched and not yet done |

## Verification
Every result is registered, so a write, tick or done pulse sampled at one rising edge shows on the outputs right after that edge. There is no extra cycle of delay. The bench drives each input on a falling edge, holds it across one rising edge, and compares the outputs at the next falling edge. This lines every check up with the edge that sampled the stimulus. For the window, the bench counts ticks exactly. It checks at 49 ticks that the window is still open, and at the 50th tick that the start pulse appears. It checks one cycle later that the pulse has gone.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_C1, ST_C2, ST_C3, ST_C4, ST_C5, ST_WIN, ST_BUSY
  } seq_state_e;

  localparam logic [7:0]  CMD_KEY1     = 8'hAA;
  localparam logic [7:0]  CMD_KEY2     = 8'h55;
  localparam logic [7:0]  CMD_SETUP    = 8'h80;
  localparam logic [7:0]  CMD_SECERASE = 8'h30;
  localparam logic [11:0] KEY_ADDR1    = 12'h555;
  localparam logic [11:0] KEY_ADDR2    = 12'h2AA;
endpackage

// File: rtl/sec_cmd_seq.sv
module sec_cmd_seq
  import sec_erase_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_low,
  input  logic [7:0]    wr_data,
  input  logic          expire,
  input  logic          erase_done,
  output logic          add_sector,
  output logic          drop_set,
  output logic          start_q,
  output logic          win_q,
  output logic          busy_q
);
  localparam logic [LW-1:0] A1 = LW'(KEY_ADDR1);
  localparam logic [LW-1:0] A2 = LW'(KEY_ADDR2);

  seq_state_e st_q, st_d;
  logic key1, key2, setup, launch;

  // Decode of the unlock and setup writes.
  assign key1  = (wr_data == CMD_KEY1)  && (wr_low == A1);
  assign key2  = (wr_data == CMD_KEY2)  && (wr_low == A2);
  assign setup = (wr_data == CMD_SETUP) && (wr_low == A1);

  always_comb begin
    st_d       = st_q;
    add_sector = 1'b0;
    drop_set   = 1'b0;
    launch     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (wr_en && key1) st_d = ST_C1;
      ST_C1:   if (wr_en) st_d = key2  ? ST_C2 : ST_IDLE;
      ST_C2:   if (wr_en) st_d = setup ? ST_C3 : ST_IDLE;
      ST_C3:   if (wr_en) st_d = key1  ? ST_C4 : ST_IDLE;
      ST_C4:   if (wr_en) st_d = key2  ? ST_C5 : ST_IDLE;
      ST_C5: begin
        if (wr_en) begin
          if (wr_data == CMD_SECERASE) begin
            add_sector = 1'b1;
            st_d       = ST_WIN;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_WIN: begin
        // A write takes priority over a tick expiring in the same cycle.
        if (wr_en) begin
          if (wr_data == CMD_SECERASE) begin
            add_sector = 1'b1;
          end else begin
            drop_set = 1'b1;
            st_d     = ST_IDLE;
          end
        end else if (expire) begin
          launch = 1'b1;
          st_d   = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (erase_done) begin
          drop_set = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      win_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= launch;
      win_q   <= (st_d == ST_WIN);
      busy_q  <= (st_d == ST_BUSY);
    end
  end
endmodule

// File: rtl/sec_win_timer.sv
module sec_win_timer #(
  parameter int TIMEOUT_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic us_tick,
  output logic expire
);
  localparam int CW = (TIMEOUT_US > 1) ? $clog2(TIMEOUT_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_US - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && us_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run && us_tick && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sec_map.sv
module sec_map #(
  parameter int NSEC = 16,
  parameter int SW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [SW-1:0]   set_idx,
  input  logic            clear,
  output logic [NSEC-1:0] map_q
);
  for (genvar i = 0; i < NSEC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        map_q[i] <= 1'b0;
      end else if (set_en && (set_idx == SW'(i))) begin
        map_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sec_erase_collector.sv
module sec_erase_collector #(
  parameter int AW         = 16,
  parameter int NSEC       = 16,
  parameter int TIMEOUT_US = 50
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            us_tick,
  input  logic            erase_done,
  output logic [NSEC-1:0] sector_map,
  output logic            erase_start,
  output logic            window_open,
  output logic            busy
);
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int LW = AW - SW;

  logic add_sector, drop_set, expire;

  sec_cmd_seq #(.LW(LW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_low     (wr_addr[LW-1:0]),
    .wr_data    (wr_data),
    .expire     (expire),
    .erase_done (erase_done),
    .add_sector (add_sector),
    .drop_set   (drop_set),
    .start_q    (erase_start),
    .win_q      (window_open),
    .busy_q     (busy)
  );

  sec_win_timer #(.TIMEOUT_US(TIMEOUT_US)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (window_open),
    .restart (add_sector),
    .us_tick (us_tick),
    .expire  (expire)
  );

  sec_map #(.NSEC(NSEC), .SW(SW)) u_map (
    .clk     (clk),
    .rst     (rst),
    .set_en  (add_sector),
    .set_idx (wr_addr[AW-1 -: SW]),
    .clear   (drop_set),
    .map_q   (sector_map)
  );
endmodule

// File: rtl/sec_erase_chk.sv
module sec_erase_chk #(
  parameter int NSEC = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            erase_done,
  input logic [NSEC-1:0] sector_map,
  input logic            erase_start,
  input logic            window_open,
  input logic            busy
);
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  p_start_enters_busy_r5: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> (busy && !window_open));

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && window_open));

  p_busy_map_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !erase_done) |=> $stable(sector_map));

  p_window_map_grows_r4: assert property (@(posedge clk) disable iff (rst)
    window_open |=> (((sector_map | $past(sector_map)) == sector_map) || (sector_map == '0)));

  p_idle_map_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (!window_open && !busy) |-> (sector_map == '0));

  p_start_has_sector_r4: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> (sector_map != '0));
endmodule

bind sec_erase_collector sec_erase_chk #(.NSEC(NSEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .erase_done  (erase_done),
  .sector_map  (sector_map),
  .erase_start (erase_start),
  .window_open (window_open),
  .busy        (busy)
);

// File: tb/sec_erase_collector_tb.sv
module sec_erase_collector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        us_tick = 1'b0;
  logic        erase_done = 1'b0;
  logic [15:0] sector_map;
  logic        erase_start, window_open, busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_erase_collector u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .us_tick(us_tick), .erase_done(erase_done), .sector_map(sector_map),
    .erase_start(erase_start), .window_open(window_open), .busy(busy)
  );

  // {address, data, expected window_open, expected sector_map}
  localparam logic [40:0] VEC [NV] = '{
    {16'h0555, 8'hAA, 1'b0, 16'h0000},
    {16'h02AA, 8'h55, 1'b0, 16'h0000},
    {16'h0555, 8'h80, 1'b0, 16'h0000},
    {16'h0555, 8'hAA, 1'b0, 16'h0000},
    {16'h02AA, 8'h55, 1'b0, 16'h0000},
    {16'h3000, 8'h30, 1'b1, 16'h0008},
    {16'hA123, 8'h30, 1'b1, 16'h0408},
    {16'h0000, 8'h30, 1'b1, 16'h0409},
    {16'hF555, 8'h30, 1'b1, 16'h8409},
    {16'h3000, 8'h30, 1'b1, 16'h8409},
    {16'h1234, 8'hF0, 1'b0, 16'h0000},
    {16'h0555, 8'hAA, 1'b0, 16'h0000},
    {16'h02AA, 8'h00, 1'b0, 16'h0000},
    {16'h0000, 8'h30, 1'b0, 16'h0000}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  task automatic open_seq(input logic [15:0] a);
    do_wr(16'h0555, 8'hAA);
    do_wr(16'h02AA, 8'h55);
    do_wr(16'h0555, 8'h80);
    do_wr(16'h0555, 8'hAA);
    do_wr(16'h02AA, 8'h55);
    do_wr(a, 8'h30);
  endtask

  task automatic done_pulse();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sector_map == 16'h0 && !window_open && !busy && !erase_start, "R1 reset state",
          {sector_map, 13'b0, window_open, busy, erase_start}, 32'h0);

    // Vector walk: R2 sequence, R4 accumulation, R7 abandon, R3 broken sequence
    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][40:25], VEC[i][24:17]);
      check(window_open == VEC[i][16], "R2/R3/R7 vector window_open", 32'(window_open), 32'(VEC[i][16]));
      check(sector_map == VEC[i][15:0], "R4/R7 vector sector_map", 32'(sector_map), 32'(VEC[i][15:0]));
    end

    // R5 expiry after 50 ticks, R10 single-cycle start
    open_seq(16'h5000);
    ticks(49);
    check(window_open && !busy && !erase_start, "R5 open after 49 ticks",
          {29'b0, window_open, busy, erase_start}, 32'h4);
    ticks(1);
    check(erase_start && busy && !window_open, "R5 start on 50th tick",
          {29'b0, window_open, busy, erase_start}, 32'h3);
    check(sector_map == 16'h0020, "R5 launched map", 32'(sector_map), 32'h0020);
    @(negedge clk);
    check(!erase_start, "R10 start one cycle", 32'(erase_start), 32'h0);

    // R8 writes ignored while busy
    open_seq(16'h9000);
    check(sector_map == 16'h0020 && busy && !window_open, "R8 busy ignores writes",
          {sector_map, 14'b0, window_open, busy}, {16'h0020, 16'h1});
    done_pulse();
    check(!busy && sector_map == 16'h0, "R8 done clears", {sector_map, 15'b0, busy}, 32'h0);

    // R6 restart on each added sector
    open_seq(16'h2000);
    ticks(30);
    do_wr(16'h7000, 8'h30);
    ticks(49);
    check(window_open && !erase_start, "R6 restarted window open", 32'(window_open), 32'h1);
    ticks(1);
    check(erase_start && sector_map == 16'h0084, "R6 launch after restart",
          {sector_map, 15'b0, erase_start}, {16'h0084, 16'h1});
    done_pulse();

    // R4 all sectors loaded
    open_seq(16'h0000);
    for (int s = 1; s < 16; s++) do_wr(16'(s << 12), 8'h30);
    check(sector_map == 16'hFFFF, "R4 all sectors", 32'(sector_map), 32'hFFFF);
    ticks(50);
    check(erase_start && sector_map == 16'hFFFF, "R4 launch all",
          {sector_map, 15'b0, erase_start}, {16'hFFFF, 16'h1});

    // R9 reset during busy and during window
    do_reset();
    check(!busy && sector_map == 16'h0, "R9 reset in busy", {sector_map, 15'b0, busy}, 32'h0);
    open_seq(16'hB000);
    check(window_open && sector_map == 16'h0800, "R2 reopen", 32'(sector_map), 32'h0800);
    do_reset();
    check(!window_open && sector_map == 16'h0 && !erase_start, "R9 reset in window",
          {sector_map, 15'b0, window_open}, 32'h0);
    ticks(60);
    check(!erase_start && !busy, "R9 no launch after reset", {30'b0, busy, erase_start}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule